// File: doc/BRIEF.md
# Serial Block-Address Entry Sequencer

This block sits on the write side of a field memory and decides, after every reset-write request, where the write pointer goes next. It counts write-clock rising edges from the request and checks the two enable inputs against a fixed four-edge pattern. If any edge of the pattern is wrong, the request is served as a plain reset and a one-cycle load-zero command is issued. If the whole pattern matches, the block takes a 13-bit block number one bit per edge. The bits come either from data bit 0 or from the input-enable pin. The block then waits out the write latency window and issues a one-cycle load-block command that carries the number.

Edges are numbered from the request. Edge 1 is the first write-clock rising edge at which the reset-write input is sampled high after it was sampled low. A block number above the last valid block puts the block into a lockup state, and only a plain reset clears it. A separate watcher raises a test-mode flag when reset-write and write-enable are held high together for too long.

Top module: `blk_addr_seq`

## Requirements
- R1: After reset, every output is 0: both load commands, busy, the lockup flag, the violation flag, the test-mode flag and the block number.
- R2: The required pattern is in_en=0 with wr_en=1 on edges 1 and 2, then in_en=1 with wr_en=0 on edges 3 and 4. If edge 1 does not match, load_zero is high for exactly the one cycle after edge 1, and busy stays low.
- R3: If edge 1 matches but one of edges 2, 3 or 4 does not, busy is high from edge 1 up to that edge. load_zero is then high for exactly the cycle after the failing edge, and busy is low from that cycle on.
- R4: When wr_en is sampled low on edge 5, the 13 address bits are taken from din0 on edges 5 through 17, and in_en is ignored.
- R5: When wr_en is sampled high on edge 5, the 13 address bits are taken from in_en on edges 5 through 17, and din0 is ignored.
- R6: The first bit captured (edge 5) is the most significant bit of blk_num, and the bit captured on edge 17 is the least significant.
- R7: For a valid number (0 to 6143), busy stays high through edge 34. load_blk is high for exactly the one cycle after edge 35, with blk_num holding the number. Busy is low in that cycle, and load_zero and load_blk are never high together.
- R8: A number above 6143 sets lock_err on edge 17, drops busy, and suppresses load_blk. lock_err stays set while no plain reset occurs.
- R9: While lock_err is set, the next request is served as a plain reset on edge 1, whatever the pattern. load_zero pulses for one cycle and lock_err clears in that same cycle.
- R10: A rising edge of rst_wr during a sequence makes proto_viol high for the single following cycle. It changes neither the sequence's timing nor its block number.
- R11: test_mode rises after the 1024th consecutive edge on which rst_wr and wr_en are both sampled high, and not earlier. It clears after the second consecutive edge with wr_en sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_wr | input | 1 | Reset-write request; its rising edge starts a sequence |
| wr_en | input | 1 | Write enable; pattern input and mode selector on edge 5 |
| in_en | input | 1 | Input enable; pattern input and serial address source in one mode |
| din0 | input | 1 | Data bit 0; serial address source in the other mode |
| load_zero | output | 1 | One-cycle command: load the write pointer with zero |
| load_blk | output | 1 | One-cycle command: load the write pointer with the start of blk_num |
| blk_num | output | 13 | Captured block number |
| busy | output | 1 | A block-entry sequence is in progress |
| lock_err | output | 1 | An out-of-range block number was entered |
| proto_viol | output | 1 | One-cycle flag: request edge ignored during a sequence |
| test_mode | output | 1 | Reset-write and write-enable were held high too long |

## Verification
Random block numbers are entered in both source modes. In each mode the pin that is not the source carries random noise, so swapping the two sources or reversing the bit order gives a wrong number. Directed failures on each of edges 1 to 4 check that each pattern position is checked on its own edge and that each failure ends in one plain reset. Numbers at 6143 and 6144, and at the all-ones value, locate the range limit exactly; a request that follows then checks recovery from lockup. Stray request edges placed at random points of a sequence, and a hold of exactly 1023 then 1024 edges, pin down the violation flag and the test-mode threshold.

// File: rtl/blk_addr_seq.sv
module blk_addr_seq #(
  parameter int BLK_W      = 13,
  parameter int BLK_MAX    = 6143,
  parameter int CHK_EDGES  = 4,
  parameter int LOAD_EDGE  = 35,
  parameter int TEST_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_wr,
  input  logic             wr_en,
  input  logic             in_en,
  input  logic             din0,
  output logic             load_zero,
  output logic             load_blk,
  output logic [BLK_W-1:0] blk_num,
  output logic             busy,
  output logic             lock_err,
  output logic             proto_viol,
  output logic             test_mode
);
  localparam int ADDR_FIRST = CHK_EDGES + 1;
  localparam int ADDR_LAST  = CHK_EDGES + BLK_W;
  localparam int CNT_W      = $clog2(LOAD_EDGE + 1);
  localparam int TCW        = $clog2(TEST_LIMIT);

  logic [CNT_W-1:0] cnt;
  logic [TCW-1:0]   tcnt;
  logic             rst_wr_q, wr_en_q, src_ie;

  wire [CNT_W-1:0] nxt     = cnt + 1'b1;
  wire             req     = rst_wr && !rst_wr_q;
  wire             want_ie = busy ? (nxt > CNT_W'(CHK_EDGES / 2)) : 1'b0;
  wire             pat_ok  = (in_en == want_ie) && (wr_en == !want_ie);
  wire             use_ie  = (nxt == CNT_W'(ADDR_FIRST)) ? wr_en : src_ie;
  wire             sbit    = use_ie ? in_en : din0;
  wire [BLK_W-1:0] shifted = {blk_num[BLK_W-2:0], sbit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; busy <= 1'b0; src_ie <= 1'b0; blk_num <= '0;
      load_zero <= 1'b0; load_blk <= 1'b0; lock_err <= 1'b0;
      proto_viol <= 1'b0; rst_wr_q <= 1'b0;
    end else begin
      load_zero  <= 1'b0;
      load_blk   <= 1'b0;
      proto_viol <= 1'b0;
      rst_wr_q   <= rst_wr;
      if (!busy) begin
        if (req) begin
          if (lock_err || !pat_ok) begin
            load_zero <= 1'b1;
            lock_err  <= 1'b0;
          end else begin
            busy <= 1'b1;
            cnt  <= CNT_W'(1);
          end
        end
      end else begin
        if (req) proto_viol <= 1'b1;
        cnt <= nxt;
        if (nxt <= CNT_W'(CHK_EDGES)) begin
          if (!pat_ok) begin
            busy      <= 1'b0;
            load_zero <= 1'b1;
          end
        end else if (nxt <= CNT_W'(ADDR_LAST)) begin
          if (nxt == CNT_W'(ADDR_FIRST)) src_ie <= wr_en;
          blk_num <= shifted;
          if (nxt == CNT_W'(ADDR_LAST) && shifted > BLK_W'(BLK_MAX)) begin
            lock_err <= 1'b1;
            busy     <= 1'b0;
          end
        end else if (nxt == CNT_W'(LOAD_EDGE)) begin
          busy     <= 1'b0;
          load_blk <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0; test_mode <= 1'b0; wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= wr_en;
      if (rst_wr && wr_en) begin
        if (tcnt != TCW'(TEST_LIMIT - 1)) tcnt <= tcnt + 1'b1;
        else test_mode <= 1'b1;
      end else begin
        tcnt <= '0;
      end
      if (!wr_en && !wr_en_q) test_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/blk_addr_seq_chk.sv
module blk_addr_seq_chk #(
  parameter int BLK_W   = 13,
  parameter int BLK_MAX = 6143
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             load_zero,
  input logic             load_blk,
  input logic [BLK_W-1:0] blk_num,
  input logic             busy,
  input logic             lock_err,
  input logic             proto_viol
);
  // R7
  no_dual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_zero && load_blk));
  // R7
  blk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_blk |=> !load_blk);
  // R7
  blk_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_blk |-> ($past(busy) && !busy));
  // R8
  blk_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_blk |-> (blk_num <= BLK_W'(BLK_MAX)));
  // R8
  err_from_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> ($past(busy) && !busy));
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_err) |-> load_zero);
  // R10
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_viol |-> ($past(busy) && !$past(proto_viol)));
endmodule

bind blk_addr_seq blk_addr_seq_chk #(.BLK_W(BLK_W), .BLK_MAX(BLK_MAX)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .load_zero(load_zero),
  .load_blk(load_blk), .blk_num(blk_num), .busy(busy), .lock_err(lock_err),
  .proto_viol(proto_viol));

// File: tb/blk_addr_seq_test.sv
module blk_addr_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_wr = 1'b0, wr_en = 1'b0, in_en = 1'b0, din0 = 1'b0;
  logic load_zero, load_blk, busy, lock_err, proto_viol, test_mode;
  logic [12:0] blk_num;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  blk_addr_seq uut (.*);

  task automatic step(input logic r, input logic w, input logic i, input logic d);
    @(negedge clk);
    rst_wr = r; wr_en = w; in_en = i; din0 = d;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {busy,lz,lb,err,viol} got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [4:0] exp_flags(input int e, input int viol_e, input logic bad);
    logic b, lb, er;
    b  = bad ? (e < 17) : (e < 35);
    lb = !bad && (e == 35);
    er = bad && (e >= 17);
    return {b, 1'b0, lb, er, e == viol_e};
  endfunction

  task automatic entry(input logic m, input logic [12:0] v, input int viol_e, input string req);
    logic bad = (v > 13'd6143);
    int last = bad ? 17 : 35;
    step(0, 0, 0, 0);
    for (int e = 1; e <= last; e++) begin
      logic r, w, i, d, bitv;
      r = (e == 1) || (e == viol_e);
      bitv = (e >= 5 && e <= 17) ? v[17-e] : 1'b0;
      if (e <= 2) begin w = 1; i = 0; d = $urandom; end
      else if (e <= 4) begin w = 0; i = 1; d = $urandom; end
      else if (e <= 17) begin
        w = (e == 5) ? m : 1'b0;
        i = m ? bitv : logic'($urandom);
        d = m ? logic'($urandom) : bitv;
      end else begin w = 0; i = 0; d = $urandom; end
      step(r, w, i, d);
      chk(req, {busy, load_zero, load_blk, lock_err, proto_viol}, exp_flags(e, viol_e, bad));
    end
    if (!bad) begin
      tests++;
      if (blk_num !== v) begin
        fails++;
        $display("FAIL %s R6: blk_num got %0d expected %0d", req, blk_num, v);
      end
    end
  endtask

  task automatic fail_at(input int k);
    step(0, 0, 0, 0);
    for (int e = 1; e <= k; e++) begin
      logic w, i;
      w = (e <= 2); i = (e > 2);
      if (e == k) begin w = ~w; i = $urandom; end
      step(e == 1, w, i, 0);
      if (e < k) chk("R3 armed", {busy, load_zero, load_blk, lock_err, proto_viol}, 5'b10000);
      else chk(k == 1 ? "R2" : "R3", {busy, load_zero, load_blk, lock_err, proto_viol}, 5'b01000);
    end
    step(0, 0, 0, 0);
    chk("R2/R3 pulse end", {busy, load_zero, load_blk, lock_err, proto_viol}, 5'b00000);
  endtask

  task automatic recover();
    step(0, 0, 0, 0);
    step(1, 0, 1, 0);
    chk("R9", {busy, load_zero, load_blk, lock_err, proto_viol}, 5'b01000);
    step(0, 0, 0, 0);
    chk("R9 idle", {busy, load_zero, load_blk, lock_err, proto_viol}, 5'b00000);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk("R1", {busy, load_zero, load_blk, lock_err, proto_viol}, 5'b00000);
    tests++;
    if (blk_num !== 13'd0 || test_mode !== 1'b0) begin
      fails++;
      $display("FAIL R1: blk_num/test %0d/%b expected 0/0", blk_num, test_mode);
    end
    @(negedge clk); rst_n = 1'b1;

    for (int k = 1; k <= 4; k++) fail_at(k);

    entry(0, 13'h1555, 0, "R4 R7");
    entry(1, 13'h0AAA, 0, "R5 R7");
    entry(0, 13'd1, 0, "R6 lsb");
    entry(1, 13'h1000, 0, "R6 msb");
    entry(0, 13'd6143, 0, "R7 max");
    entry(1, 13'd6144, 0, "R8");
    recover();
    entry(0, 13'h1FFF, 9, "R8 R10");
    recover();
    entry(1, 13'd77, 20, "R10");
    entry(0, 13'd4000, 3, "R10 early");

    for (int n = 0; n < 24; n++) begin
      logic m = $urandom;
      logic [12:0] v = $urandom;
      int ve = (n % 3 == 0) ? int'(3 + $urandom % 14) : 0;
      entry(m, v, ve, m ? "R5 rand" : "R4 rand");
      if (v > 13'd6143) recover();
    end

    step(0, 0, 0, 0);
    for (int c = 1; c <= 1023; c++) step(1, 1, 0, 0);
    chk("R11 below", {test_mode, 4'b0}, 5'b00000);
    step(1, 1, 0, 0);
    chk("R11 set", {test_mode, 4'b0}, 5'b10000);
    step(1, 0, 0, 0);
    chk("R11 hold", {test_mode, 4'b0}, 5'b10000);
    step(1, 0, 0, 0);
    chk("R11 clear", {test_mode, 4'b0}, 5'b00000);
    step(0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule